// File: doc/BRIEF.md
# UART FIFO-Level Interrupt Controller

This block produces the interrupt line of a UART whose transmit and receive FIFOs each hold `FIFO_DEPTH` entries (32 by default). It watches the two FIFO fill counts, a receive-idle timeout flag and four one-cycle receive error pulses. From these it keeps a sticky raw status register, a mask, a masked view and a write-one-to-clear port. Every source feeds one registered interrupt output.

Software chooses a fill-level trigger for each direction from five fractions of the FIFO depth. The receive-level source fires when enough data has arrived. The transmit-level source fires when the transmit FIFO has drained far enough. The timeout source covers data that sits below the receive trigger. Registers are reached through a small write/read port: writes take effect at the next clock edge, and reads are combinational.

Top module: `uart_irq_ctrl`

Register addresses: 0 level select (receive code in bits 2:0, transmit code in bits 5:3), 1 mask, 2 raw status (read only), 3 masked status (read only), 4 clear (write only, reads 0). Status bit positions: 0 receive level, 1 transmit level, 2 receive timeout, 3 framing error, 4 parity error, 5 break error, 6 overrun error.

## Requirements
- R1: After reset the level-select register reads 0x12 (both codes 2, i.e. one half), the mask reads 0, raw status reads 0 while no source is active, and `irq_o` is low.
- R2: Raw bit 0 sets when `rx_cnt_i` is at or above the receive trigger. The trigger is DEPTH×k/8, with code 0,1,2,3,4 giving k = 1,2,4,6,7, and codes 5 to 7 acting as code 4.
- R3: Raw bit 1 sets when `tx_cnt_i` is at or below the transmit trigger, which uses the same code-to-level mapping applied to bits 5:3.
- R4: Raw bit 2 sets when `rx_idle_to_i` is high at a clock edge.
- R5: A high pulse on the framing, parity, break or overrun input sets raw bit 3, 4, 5 or 6 respectively.
- R6: A raw bit becomes visible at address 2 one clock edge after its event and stays set after the event ends, until it is cleared.
- R7: Writing address 4 clears every raw bit whose write-data bit is 1. Zero bits have no effect.
- R8: A clear written in the same cycle as a new event on that bit leaves the bit set.
- R9: Address 3 reads the raw status ANDed with the mask at address 1.
- R10: `irq_o` is registered: it is high one edge after any masked bit is set, and low one edge after none is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_cnt_i | input | CNT_W | Receive FIFO fill count |
| tx_cnt_i | input | CNT_W | Transmit FIFO fill count |
| rx_idle_to_i | input | 1 | Receive idle timeout indication |
| frame_err_i | input | 1 | Framing error pulse |
| parity_err_i | input | 1 | Parity error pulse |
| break_err_i | input | 1 | Break error pulse |
| overrun_err_i | input | 1 | Overrun error pulse |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | 1 | Combined registered interrupt |

## Verification
Fill counts are driven one below and exactly at each tested trigger: codes 0 and 4, the reserved code 7, and the transmit code 1. This separates an off-by-one compare, a wrong fraction and a wrong direction of comparison. Error and timeout pulses are applied one at a time and then accumulated, which exposes swapped bit positions and non-sticky storage. Clears are issued with zero data, with matching data, and together with a new event; these cases distinguish a plain write from write-one-to-clear and show the priority of the event over the clear. The mask is toggled while status is held, and the interrupt is sampled both one and two edges afterwards, to confirm the register stage on the output.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
   localparam int unsigned SRC_N = 7;

   // status bit positions
   localparam int unsigned B_RXLVL  = 0;
   localparam int unsigned B_TXLVL  = 1;
   localparam int unsigned B_RXTO   = 2;
   localparam int unsigned B_FRAME  = 3;
   localparam int unsigned B_PARITY = 4;
   localparam int unsigned B_BREAK  = 5;
   localparam int unsigned B_OVRUN  = 6;

   // register addresses
   localparam int unsigned A_LVL    = 0;
   localparam int unsigned A_MASK   = 1;
   localparam int unsigned A_RAW    = 2;
   localparam int unsigned A_MSK_ST = 3;
   localparam int unsigned A_CLR    = 4;

   localparam int unsigned SEL_W = 3;
   typedef enum logic [SEL_W-1:0] {
      LVL_EIGHTH   = 3'd0,
      LVL_QUARTER  = 3'd1,
      LVL_HALF     = 3'd2,
      LVL_3QUARTER = 3'd3,
      LVL_7EIGHTHS = 3'd4
   } lvl_code_e;

   // eighths of depth selected by a code; reserved codes act as 7/8
   function automatic int unsigned lvl_eighths(input logic [SEL_W-1:0] code);
      case (code)
         LVL_EIGHTH:   return 1;
         LVL_QUARTER:  return 2;
         LVL_HALF:     return 4;
         LVL_3QUARTER: return 6;
         default:      return 7;
      endcase
   endfunction
endpackage

// File: rtl/uirq_thresh.sv
module uirq_thresh
   import uirq_pkg::*;
#(
   parameter int unsigned DEPTH    = 32,
   parameter int unsigned CNT_W    = $clog2(DEPTH + 1),
   parameter bit          AT_ABOVE = 1'b1
) (
   input  logic [SEL_W-1:0] sel_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] thr_o,
   output logic             hit_o
);
   localparam int unsigned STEP = DEPTH / 8;

   always_comb begin
      thr_o = CNT_W'(STEP * lvl_eighths(sel_i));
   end

   generate
      if (AT_ABOVE) begin : g_above
         assign hit_o = (cnt_i >= thr_o);
      end else begin : g_below
         assign hit_o = (cnt_i <= thr_o);
      end
   endgenerate
endmodule

// File: rtl/uirq_cfg.sv
module uirq_cfg
   import uirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned NSRC   = SRC_N
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [SEL_W-1:0]  rx_sel_o,
   output logic [SEL_W-1:0]  tx_sel_o,
   output logic [NSRC-1:0]   mask_o,
   output logic [NSRC-1:0]   clr_o
);
   logic wr_lvl, wr_mask, wr_clr;

   assign wr_lvl  = we_i && (addr_i == ADDR_W'(A_LVL));
   assign wr_mask = we_i && (addr_i == ADDR_W'(A_MASK));
   assign wr_clr  = we_i && (addr_i == ADDR_W'(A_CLR));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sel_o <= LVL_HALF;
         tx_sel_o <= LVL_HALF;
         mask_o   <= '0;
      end else begin
         if (wr_lvl) begin
            rx_sel_o <= wdata_i[SEL_W-1:0];
            tx_sel_o <= wdata_i[2*SEL_W-1:SEL_W];
         end
         if (wr_mask) mask_o <= wdata_i[NSRC-1:0];
      end
   end

   assign clr_o = wr_clr ? wdata_i[NSRC-1:0] : '0;

   p_mask_hold_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_mask |=> $stable(mask_o));
endmodule

// File: rtl/uirq_status.sv
module uirq_status #(
   parameter int unsigned NSRC = 7
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] evt_i,
   input  logic [NSRC-1:0] clr_i,
   output logic [NSRC-1:0] raw_o
);
   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        raw_o[i] <= 1'b0;
            else if (evt_i[i]) raw_o[i] <= 1'b1;
            else if (clr_i[i]) raw_o[i] <= 1'b0;
         end

         p_evt_wins_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            evt_i[i] |=> raw_o[i]);
         p_clr_r7 : assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[i] && !evt_i[i]) |=> !raw_o[i]);
         p_sticky_r6 : assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_i[i] && !evt_i[i]) |=> $stable(raw_o[i]));
      end
   endgenerate
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uirq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 32,
   parameter int unsigned CNT_W      = $clog2(FIFO_DEPTH + 1),
   parameter int unsigned ADDR_W     = 3,
   parameter int unsigned DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CNT_W-1:0]  rx_cnt_i,
   input  logic [CNT_W-1:0]  tx_cnt_i,
   input  logic              rx_idle_to_i,
   input  logic              frame_err_i,
   input  logic              parity_err_i,
   input  logic              break_err_i,
   input  logic              overrun_err_i,
   input  logic              reg_we_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);
   generate
      if (FIFO_DEPTH < 8 || (FIFO_DEPTH % 8) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a nonzero multiple of 8");
      end
      if (DATA_W < 2 * SEL_W || DATA_W < SRC_N) begin : g_bad_data
         $error("DATA_W too narrow for the register fields");
      end
      if ((1 << ADDR_W) <= A_CLR) begin : g_bad_addr
         $error("ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [SEL_W-1:0] rx_sel, tx_sel;
   logic [SRC_N-1:0] mask, clr, evt, raw, masked;
   logic [CNT_W-1:0] rx_thr, tx_thr;
   logic             rx_hit, tx_hit;

   uirq_cfg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSRC(SRC_N)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
      .wdata_i(reg_wdata_i), .rx_sel_o(rx_sel), .tx_sel_o(tx_sel),
      .mask_o(mask), .clr_o(clr));

   uirq_thresh #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .AT_ABOVE(1'b1)) u_rx_thr (
      .sel_i(rx_sel), .cnt_i(rx_cnt_i), .thr_o(rx_thr), .hit_o(rx_hit));

   uirq_thresh #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .AT_ABOVE(1'b0)) u_tx_thr (
      .sel_i(tx_sel), .cnt_i(tx_cnt_i), .thr_o(tx_thr), .hit_o(tx_hit));

   always_comb begin
      evt           = '0;
      evt[B_RXLVL]  = rx_hit;
      evt[B_TXLVL]  = tx_hit;
      evt[B_RXTO]   = rx_idle_to_i;
      evt[B_FRAME]  = frame_err_i;
      evt[B_PARITY] = parity_err_i;
      evt[B_BREAK]  = break_err_i;
      evt[B_OVRUN]  = overrun_err_i;
   end

   uirq_status #(.NSRC(SRC_N)) u_status (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr), .raw_o(raw));

   assign masked = raw & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_o <= 1'b0;
      else        irq_o <= |masked;
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         ADDR_W'(A_LVL): begin
            reg_rdata_o[SEL_W-1:0]       = rx_sel;
            reg_rdata_o[2*SEL_W-1:SEL_W] = tx_sel;
         end
         ADDR_W'(A_MASK):   reg_rdata_o[SRC_N-1:0] = mask;
         ADDR_W'(A_RAW):    reg_rdata_o[SRC_N-1:0] = raw;
         ADDR_W'(A_MSK_ST): reg_rdata_o[SRC_N-1:0] = masked;
         default:           reg_rdata_o = '0;
      endcase
   end

   p_rxlvl_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (rx_cnt_i >= rx_thr) |=> raw[B_RXLVL]);
   p_txlvl_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt_i <= tx_thr) |=> raw[B_TXLVL]);
   p_rto_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      rx_idle_to_i |=> raw[B_RXTO]);
   p_frame_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      frame_err_i |=> raw[B_FRAME]);
   p_irq_set_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (|(raw & mask)) |=> irq_o);
   p_irq_clr_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !(|(raw & mask)) |=> !irq_o);
endmodule

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
   localparam int CNT_W = 6;

   logic clk = 0, rst_n = 0;
   logic [CNT_W-1:0] rx_cnt = 0, tx_cnt = 20;
   logic rto = 0, fe = 0, pe = 0, be = 0, oe = 0;
   logic we = 0;
   logic [2:0] addr = 0;
   logic [7:0] wdata = 0, rdata;
   logic irq;

   uart_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .rx_cnt_i(rx_cnt), .tx_cnt_i(tx_cnt),
      .rx_idle_to_i(rto), .frame_err_i(fe), .parity_err_i(pe),
      .break_err_i(be), .overrun_err_i(oe), .reg_we_i(we),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .irq_o(irq));

   always #4 clk = ~clk;

   typedef struct { logic [7:0] exp; string tag; } item_t;
   item_t sb[$];
   int n_run = 0, n_fail = 0;
   logic rd_v = 0;
   bit done = 0;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   // monitor: pops expected reads and compares
   initial forever begin
      @(negedge clk);
      #1;
      if (rd_v && sb.size() > 0) begin
         item_t e;
         e = sb.pop_front();
         chk(rdata, e.exp, e.tag);
      end
   end

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      item_t e;
      @(negedge clk);
      addr = a;
      e.exp = exp; e.tag = tag;
      sb.push_back(e);
      rd_v = 1;
      #2 rd_v = 0;
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      we = 1; addr = a; wdata = d;
      @(negedge clk);
      we = 0;
   endtask

   task automatic irq_now(input logic exp, input string tag);
      #1 chk({7'd0, irq}, {7'd0, exp}, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_fail++; n_run++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      irq_now(1'b0, "R1 irq after reset");
      rd(0, 8'h12, "R1 level select reset");
      rd(1, 8'h00, "R1 mask reset");
      rd(2, 8'h00, "R1 raw reset");
      // receive level, default half (16)
      rx_cnt = 15; rd(2, 8'h00, "R2 rx 15 below half");
      rx_cnt = 16; rd(2, 8'h01, "R2 rx 16 at half");
      rx_cnt = 0;  rd(2, 8'h01, "R6 rx bit sticky");
      wr(4, 8'h00); rd(2, 8'h01, "R7 zero clear no effect");
      wr(4, 8'h01); rd(2, 8'h00, "R7 clear rx bit");
      // code 0 (4) for rx, code 1 (8) for tx
      wr(0, 8'h08); rd(0, 8'h08, "R2 level select readback");
      rx_cnt = 3; rd(2, 8'h00, "R2 rx 3 below 1/8");
      rx_cnt = 4; rd(2, 8'h01, "R2 rx 4 at 1/8");
      rx_cnt = 0; wr(4, 8'h01);
      // code 4 (28)
      wr(0, 8'h0C);
      rx_cnt = 27; rd(2, 8'h00, "R2 rx 27 below 7/8");
      rx_cnt = 28; rd(2, 8'h01, "R2 rx 28 at 7/8");
      rx_cnt = 0; wr(4, 8'h01);
      // reserved code 7 acts as 7/8
      wr(0, 8'h0F);
      rx_cnt = 27; rd(2, 8'h00, "R2 reserved code 27");
      rx_cnt = 28; rd(2, 8'h01, "R2 reserved code 28");
      rx_cnt = 0; wr(4, 8'h01); rd(2, 8'h00, "R7 clear after reserved");
      // transmit level code 1 (8)
      tx_cnt = 9; rd(2, 8'h00, "R3 tx 9 above quarter");
      tx_cnt = 8; rd(2, 8'h02, "R3 tx 8 at quarter");
      tx_cnt = 20; wr(4, 8'h02); rd(2, 8'h00, "R3 tx cleared");
      // timeout
      rto = 1; rd(2, 8'h04, "R4 timeout sets");
      rto = 0; rd(2, 8'h04, "R6 timeout sticky");
      wr(4, 8'h04);
      // errors one at a time
      fe = 1; rd(2, 8'h08, "R5 framing bit 3"); fe = 0;
      pe = 1; rd(2, 8'h18, "R5 parity bit 4"); pe = 0;
      be = 1; rd(2, 8'h38, "R5 break bit 5"); be = 0;
      oe = 1; rd(2, 8'h78, "R5 overrun bit 6"); oe = 0;
      // mask and interrupt
      irq_now(1'b0, "R10 irq low with zero mask");
      rd(3, 8'h00, "R9 masked zero");
      wr(1, 8'h08);
      irq_now(1'b0, "R10 irq registered lag");
      rd(3, 8'h08, "R9 masked view");
      irq_now(1'b1, "R10 irq high");
      // clear concurrent with new event
      @(negedge clk);
      we = 1; addr = 4; wdata = 8'h08; fe = 1;
      @(negedge clk);
      we = 0; fe = 0;
      rd(2, 8'h78, "R8 event beats clear");
      wr(4, 8'h78);
      irq_now(1'b1, "R10 irq lag on clear");
      rd(3, 8'h00, "R9 masked after clear");
      irq_now(1'b0, "R10 irq low after clear");
      rd(4, 8'h00, "R7 clear reads zero");
      rd(1, 8'h08, "R9 mask readback");
      @(negedge clk);
      @(negedge clk);
      finish_run();
   end
endmodule